// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block is the execution engine that sits behind a serial command parser in a four-channel digital potentiometer. It holds one volatile wiper code per channel and a bank of four retained preset slots per channel. The parser hands it one decoded command per clock: load a wiper directly, store a preset, copy between a preset and a wiper (for one channel or for all four at once), or nudge a wiper one step up or down. The four wiper codes leave the block as a flat bus for the tap decoders.

Preset stores model a slow non-volatile programming cycle. An accepted store updates the slot and then holds a busy window for a parameterised number of clocks. During that window further stores are dropped, while wiper commands and reads keep working. An active-low protect input blocks every store. Leaving reset, the block recalls preset slot 0 of each channel into that channel's wiper. The preset cells have no reset, so their contents survive it.

The controller has three states. RECALL is entered on reset and always moves to IDLE on the next clock, loading every wiper from slot 0 on that edge. IDLE moves to BUSY when a store command arrives with protect released, and otherwise stays in IDLE. BUSY counts down its window and returns to IDLE when the count reaches zero.

Top module: `quad_wiper_bank`

## Requirements
- R1: Channel p's wiper code appears on `wiper_codes[8p+7:8p]`. Code 00h is the low end and FFh the high end. A command aimed at one channel leaves the other three lanes unchanged.
- R2: Opcode 1 (load wiper) writes `cmd_data` into the wiper of `cmd_pot` on the next clock. Neither `wp_n` nor the busy window affects it.
- R3: Opcode 2 (store preset) writes `cmd_data` into slot `cmd_slot` of channel `cmd_pot`. It is accepted only when `wp_n` is 1 and no write window is open.
- R4: While reset is held, all wipers read 00h and `busy` is 0. On the first clock after release, each wiper loads its channel's slot 0 and any command in that cycle is dropped. Preset slots keep their contents through reset.
- R5: Opcode 3 copies slot `cmd_slot` of `cmd_pot` into that channel's wiper. Opcode 4 copies that wiper into slot `cmd_slot` of the same channel, under the same acceptance rule as R3.
- R6: Opcode 5 copies slot `cmd_slot` into the wiper of all four channels. Opcode 6 copies all four wipers into their own slot `cmd_slot`, under the acceptance rule of R3.
- R7: An accepted store (opcode 2, 4 or 6) raises `busy` from the next clock for exactly WRITE_CYCLES clocks. After that, `busy` returns to 0.
- R8: With `wp_n` at 0, opcodes 2, 4 and 6 change no slot and open no window.
- R9: While `busy` is 1, opcodes 2, 4 and 6 change no slot and do not extend the window.
- R10: Opcode 7 raises the wiper of `cmd_pot` by one and opcode 8 lowers it by one. Both saturate: 7 at FFh and 8 at 00h leave the code unchanged.
- R11: The read port registers `rd_kind`/`rd_pot`/`rd_slot` on each clock. `rd_data` then shows the current contents of that target: kind 0 is a wiper, kind 1 is a slot, kind 2 is status with bit 0 = `busy` and the other bits 0, and kind 3 reads 00h.
- R12: Opcodes 0 and 9 to 15, and any cycle with `cmd_valid` low, change no wiper, no slot and no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the parser |
| cmd_op | input | 4 | Command opcode |
| cmd_pot | input | 2 | Target channel |
| cmd_slot | input | 2 | Target preset slot |
| cmd_data | input | 8 | Value for load or store |
| wp_n | input | 1 | Store protect, active low |
| rd_kind | input | 2 | Read target kind |
| rd_pot | input | 2 | Read channel |
| rd_slot | input | 2 | Read slot |
| rd_data | output | 8 | Read value |
| busy | output | 1 | Write cycle in progress |
| wiper_codes | output | 32 | Four wiper codes, channel 0 in the low byte |

## Verification
On every clock, the assertions check the following:
- the recall edge after reset;
- the exact length of every busy window;
- that protect keeps the window closed;
- that slots hold still while the window is open;
- that direct wiper loads land on the addressed lane;
- saturating steps in both directions.

Some behaviour depends on stored history, and only the bench's scenarios can show it:
- that a preset written before a reset comes back as the wiper after it;
- that dropped stores leave the old slot contents readable;
- that a global copy touches each channel's own slot;
- that the status byte tracks the window.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    typedef enum logic [3:0] {
        OP_NOP               = 4'd0,
        OP_WR_WIPER          = 4'd1,
        OP_WR_SLOT           = 4'd2,
        OP_SLOT_TO_WIPER     = 4'd3,
        OP_WIPER_TO_SLOT     = 4'd4,
        OP_ALL_SLOT_TO_WIPER = 4'd5,
        OP_ALL_WIPER_TO_SLOT = 4'd6,
        OP_STEP_UP           = 4'd7,
        OP_STEP_DOWN         = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_RECALL = 2'd0,
        ST_IDLE   = 2'd1,
        ST_BUSY   = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        RD_WIPER  = 2'd0,
        RD_SLOT   = 2'd1,
        RD_STATUS = 2'd2,
        RD_NONE   = 2'd3
    } rdkind_e;

    // Per-channel action strobes produced by the controller.
    typedef struct packed {
        logic recall;
        logic wr_wiper;
        logic from_slot;
        logic step_up;
        logic step_dn;
        logic wr_slot;
        logic to_slot;
    } pot_act_t;

endpackage

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
    import wrb_pkg::*;
#(
    parameter int N_POTS       = 4,
    parameter int POT_AW       = 2,
    parameter int WRITE_CYCLES = 100000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [3:0]                  cmd_op,
    input  logic [POT_AW-1:0]           cmd_pot,
    input  logic                        wp_n,
    output pot_act_t [N_POTS-1:0]       acts,
    output logic                        busy,
    output logic                        ready
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

    state_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    op_e              op;
    logic             store_cmd;

    assign op = op_e'(cmd_op);

    always_comb begin
        store_cmd = cmd_valid &&
                    (op == OP_WR_SLOT || op == OP_WIPER_TO_SLOT ||
                     op == OP_ALL_WIPER_TO_SLOT);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RECALL: state_d = ST_IDLE;
            ST_IDLE: begin
                if (store_cmd && wp_n) begin
                    state_d = ST_BUSY;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_RECALL;
        endcase
    end

    // Outputs
    always_comb begin
        logic take;
        logic store_ok;
        logic hit;
        busy     = (state_q == ST_BUSY);
        ready    = (state_q != ST_RECALL);
        take     = cmd_valid && ready;
        store_ok = (state_q == ST_IDLE) && wp_n;
        hit      = 1'b0;
        for (int p = 0; p < N_POTS; p++) begin
            acts[p]        = '0;
            acts[p].recall = (state_q == ST_RECALL);
            hit            = (cmd_pot == POT_AW'(p));
            if (take) begin
                unique case (op)
                    OP_WR_WIPER:          acts[p].wr_wiper  = hit;
                    OP_SLOT_TO_WIPER:     acts[p].from_slot = hit;
                    OP_ALL_SLOT_TO_WIPER: acts[p].from_slot = 1'b1;
                    OP_STEP_UP:           acts[p].step_up   = hit;
                    OP_STEP_DOWN:         acts[p].step_dn   = hit;
                    OP_WR_SLOT:           acts[p].wr_slot   = hit && store_ok;
                    OP_WIPER_TO_SLOT:     acts[p].to_slot   = hit && store_ok;
                    OP_ALL_WIPER_TO_SLOT: acts[p].to_slot   = store_ok;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/wrb_pot.sv
module wrb_pot
    import wrb_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int N_SLOTS = 4,
    parameter int SLOT_AW = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  pot_act_t                    act,
    input  logic [SLOT_AW-1:0]          slot,
    input  logic [CODE_W-1:0]           wdata,
    output logic [CODE_W-1:0]           wiper,
    output logic [N_SLOTS*CODE_W-1:0]   slots
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] wiper_q;
    logic [CODE_W-1:0] picked;

    assign picked = slots[slot*CODE_W +: CODE_W];

    // Wiper: recall has top priority, then direct load, copy, step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= '0;
        end else if (act.recall) begin
            wiper_q <= slots[CODE_W-1:0];
        end else if (act.wr_wiper) begin
            wiper_q <= wdata;
        end else if (act.from_slot) begin
            wiper_q <= picked;
        end else if (act.step_up && wiper_q != CODE_MAX) begin
            wiper_q <= wiper_q + CODE_W'(1);
        end else if (act.step_dn && wiper_q != '0) begin
            wiper_q <= wiper_q - CODE_W'(1);
        end
    end

    assign wiper = wiper_q;

    // Retained preset cells: no reset, so contents survive rst_n.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_cell
        logic [CODE_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (act.wr_slot && slot == SLOT_AW'(s)) begin
                cell_q <= wdata;
            end else if (act.to_slot && slot == SLOT_AW'(s)) begin
                cell_q <= wiper_q;
            end
        end
        assign slots[s*CODE_W +: CODE_W] = cell_q;
    end

endmodule

// File: rtl/wrb_rdmux.sv
module wrb_rdmux
    import wrb_pkg::*;
#(
    parameter int CODE_W  = 8,
    parameter int N_POTS  = 4,
    parameter int N_SLOTS = 4,
    parameter int POT_AW  = 2,
    parameter int SLOT_AW = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          rd_kind,
    input  logic [POT_AW-1:0]                   rd_pot,
    input  logic [SLOT_AW-1:0]                  rd_slot,
    input  logic [N_POTS*CODE_W-1:0]            wipers,
    input  logic [N_POTS*N_SLOTS*CODE_W-1:0]    bank,
    input  logic                                busy,
    output logic [CODE_W-1:0]                   rd_data
);

    logic [1:0]         kind_q;
    logic [POT_AW-1:0]  pot_q;
    logic [SLOT_AW-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= '0;
            pot_q  <= '0;
            slot_q <= '0;
        end else begin
            kind_q <= rd_kind;
            pot_q  <= rd_pot;
            slot_q <= rd_slot;
        end
    end

    always_comb begin
        unique case (rdkind_e'(kind_q))
            RD_WIPER:  rd_data = wipers[pot_q*CODE_W +: CODE_W];
            RD_SLOT:   rd_data = bank[(pot_q*N_SLOTS + slot_q)*CODE_W +: CODE_W];
            RD_STATUS: rd_data = CODE_W'(busy);
            RD_NONE:   rd_data = '0;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
    import wrb_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int N_POTS       = 4,
    parameter int N_SLOTS      = 4,
    parameter int WRITE_CYCLES = 100000,
    parameter int POT_AW       = $clog2(N_POTS),
    parameter int SLOT_AW      = $clog2(N_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [3:0]                  cmd_op,
    input  logic [POT_AW-1:0]           cmd_pot,
    input  logic [SLOT_AW-1:0]          cmd_slot,
    input  logic [CODE_W-1:0]           cmd_data,
    input  logic                        wp_n,
    input  logic [1:0]                  rd_kind,
    input  logic [POT_AW-1:0]           rd_pot,
    input  logic [SLOT_AW-1:0]          rd_slot,
    output logic [CODE_W-1:0]           rd_data,
    output logic                        busy,
    output logic [N_POTS*CODE_W-1:0]    wiper_codes
);

    localparam int BANK_W = N_POTS * N_SLOTS * CODE_W;

    pot_act_t [N_POTS-1:0] acts;
    logic                  ready;
    logic [BANK_W-1:0]     slot_bank;

    wrb_ctrl #(
        .N_POTS       (N_POTS),
        .POT_AW       (POT_AW),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_pot   (cmd_pot),
        .wp_n      (wp_n),
        .acts      (acts),
        .busy      (busy),
        .ready     (ready)
    );

    for (genvar p = 0; p < N_POTS; p++) begin : g_pot
        wrb_pot #(
            .CODE_W  (CODE_W),
            .N_SLOTS (N_SLOTS),
            .SLOT_AW (SLOT_AW)
        ) u_pot (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (acts[p]),
            .slot  (cmd_slot),
            .wdata (cmd_data),
            .wiper (wiper_codes[p*CODE_W +: CODE_W]),
            .slots (slot_bank[p*N_SLOTS*CODE_W +: N_SLOTS*CODE_W])
        );
    end

    wrb_rdmux #(
        .CODE_W  (CODE_W),
        .N_POTS  (N_POTS),
        .N_SLOTS (N_SLOTS),
        .POT_AW  (POT_AW),
        .SLOT_AW (SLOT_AW)
    ) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_kind (rd_kind),
        .rd_pot  (rd_pot),
        .rd_slot (rd_slot),
        .wipers  (wiper_codes),
        .bank    (slot_bank),
        .busy    (busy),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/wrb_chk.sv
module wrb_chk
    import wrb_pkg::*;
#(
    parameter int CODE_W       = 8,
    parameter int N_POTS       = 4,
    parameter int N_SLOTS      = 4,
    parameter int POT_AW       = 2,
    parameter int WRITE_CYCLES = 100000
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cmd_valid,
    input logic [3:0]                        cmd_op,
    input logic [POT_AW-1:0]                 cmd_pot,
    input logic [CODE_W-1:0]                 cmd_data,
    input logic                              wp_n,
    input logic                              busy,
    input logic                              ready,
    input logic [N_POTS*CODE_W-1:0]          wiper_codes,
    input logic [N_POTS*N_SLOTS*CODE_W-1:0]  bank
);

    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [N_POTS*CODE_W-1:0] slot0;
    logic [CODE_W-1:0]        sel_w, now_at_prev;
    logic                     p_valid, p_ready;
    logic [3:0]               p_op;
    logic [POT_AW-1:0]        p_pot;
    logic [CODE_W-1:0]        p_data, p_selw;
    int                       run_cnt;

    for (genvar p = 0; p < N_POTS; p++) begin : g_s0
        assign slot0[p*CODE_W +: CODE_W] = bank[p*N_SLOTS*CODE_W +: CODE_W];
    end

    assign sel_w       = wiper_codes[cmd_pot*CODE_W +: CODE_W];
    assign now_at_prev = wiper_codes[p_pot*CODE_W +: CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            p_ready <= 1'b0;
            p_op    <= '0;
            p_pot   <= '0;
            p_data  <= '0;
            p_selw  <= '0;
            run_cnt <= 0;
        end else begin
            p_valid <= cmd_valid;
            p_ready <= ready;
            p_op    <= cmd_op;
            p_pot   <= cmd_pot;
            p_data  <= cmd_data;
            p_selw  <= sel_w;
            run_cnt <= busy ? run_cnt + 1 : 0;
        end
    end

    // R4
    recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (ready && wiper_codes == $past(slot0)));

    // R2
    wr_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_ready && p_op == OP_WR_WIPER) |-> now_at_prev == p_data);

    // R10
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_ready && p_op == OP_STEP_UP) |->
            now_at_prev == ((p_selw == CODE_MAX) ? CODE_MAX : p_selw + CODE_W'(1)));

    // R10
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid && p_ready && p_op == OP_STEP_DOWN) |->
            now_at_prev == ((p_selw == '0) ? '0 : p_selw - CODE_W'(1)));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < WRITE_CYCLES);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_cnt == WRITE_CYCLES);

    // R8
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wp_n) |=> !busy);

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank));

endmodule

bind quad_wiper_bank wrb_chk #(
    .CODE_W       (CODE_W),
    .N_POTS       (N_POTS),
    .N_SLOTS      (N_SLOTS),
    .POT_AW       (POT_AW),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_pot     (cmd_pot),
    .cmd_data    (cmd_data),
    .wp_n        (wp_n),
    .busy        (busy),
    .ready       (ready),
    .wiper_codes (wiper_codes),
    .bank        (slot_bank)
);

// File: tb/quad_wiper_bank_tb.sv
module quad_wiper_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WC         = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_pot = '0;
    logic [1:0]  cmd_slot = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic [1:0]  rd_kind = '0;
    logic [1:0]  rd_pot = '0;
    logic [1:0]  rd_slot = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic [31:0] wiper_codes;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_wiper_bank #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pot(cmd_pot), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
        .wp_n(wp_n), .rd_kind(rd_kind), .rd_pot(rd_pot), .rd_slot(rd_slot),
        .rd_data(rd_data), .busy(busy), .wiper_codes(wiper_codes)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    bit cmp_en   = 0;

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int mw[4];
    int md[4][4];
    int mbusy = 0;
    bit mrec  = 1;
    int rk = 0, rp = 0, rs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) mw[p] = 0;
            mbusy = 0; mrec = 1; rk = 0; rp = 0; rs = 0;
        end else begin
            if (mrec) begin
                for (int p = 0; p < 4; p++) mw[p] = md[p][0];
                mrec = 0;
            end else begin
                bit ok;
                ok = (mbusy == 0) && wp_n;
                if (mbusy > 0) mbusy--;
                if (cmd_valid) begin
                    case (int'(cmd_op))
                        1: mw[cmd_pot] = cmd_data;
                        2: if (ok) begin md[cmd_pot][cmd_slot] = cmd_data; mbusy = WC; end
                        3: mw[cmd_pot] = md[cmd_pot][cmd_slot];
                        4: if (ok) begin md[cmd_pot][cmd_slot] = mw[cmd_pot]; mbusy = WC; end
                        5: for (int p = 0; p < 4; p++) mw[p] = md[p][cmd_slot];
                        6: if (ok) begin
                               for (int p = 0; p < 4; p++) md[p][cmd_slot] = mw[p];
                               mbusy = WC;
                           end
                        7: if (mw[cmd_pot] < 255) mw[cmd_pot]++;
                        8: if (mw[cmd_pot] > 0) mw[cmd_pot]--;
                        default: ;
                    endcase
                end
            end
            rk = rd_kind; rp = rd_pot; rs = rd_slot;
        end
    end

    function automatic int exp_rd();
        case (rk)
            0: return mw[rp];
            1: return md[rp][rs];
            2: return (mbusy > 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            for (int p = 0; p < 4; p++) chk("R1 model wiper lane", int'(wiper_codes[p*8 +: 8]), mw[p]);
            chk("R7 model busy", int'(busy), (mbusy > 0) ? 1 : 0);
            chk("R11 model read port", int'(rd_data), exp_rd());
        end
    end

    function automatic int val(int p, int s);
        return (p*64 + s*17 + 5) % 256;
    endfunction

    function automatic int lane(int p);
        return int'(wiper_codes[p*8 +: 8]);
    endfunction

    task automatic send(int op, int pot, int slot, int data);
        cmd_op = 4'(op); cmd_pot = 2'(pot); cmd_slot = 2'(slot); cmd_data = 8'(data);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_wait();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(int kind, int pot, int slot, output int v);
        rd_kind = 2'(kind); rd_pot = 2'(pot); rd_slot = 2'(slot);
        @(negedge clk);
        v = int'(rd_data);
    endtask

    task automatic pulse_reset();
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 busy low in reset", int'(busy), 0);
        chk("R4 wipers zero in reset", int'(wiper_codes), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog all-reqs actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int v, n, snap;
        for (int p = 0; p < 4; p++) for (int s = 0; s < 4; s++) md[p][s] = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // Fill every preset (R3)
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++) begin
                send(2, p, s, val(p, s));
                idle_wait();
            end

        // R4: reset recalls slot 0
        pulse_reset();
        for (int p = 0; p < 4; p++) chk("R4 recall slot0", lane(p), val(p, 0));
        cmp_en = 1;

        // R1: lane isolation
        send(1, 1, 0, 8'hC3);
        chk("R1 lane1", lane(1), 8'hC3);
        chk("R1 lane0 kept", lane(0), val(0, 0));
        chk("R1 lane2 kept", lane(2), val(2, 0));
        chk("R1 lane3 kept", lane(3), val(3, 0));

        // R2: wiper load ignores protect
        wp_n = 1'b0;
        send(1, 2, 0, 8'h5A);
        chk("R2 load under protect", lane(2), 8'h5A);
        wp_n = 1'b1;

        // R3: store and read back
        send(2, 3, 2, 8'hA7);
        idle_wait();
        rd(1, 3, 2, v);
        chk("R3 store readback", v, 8'hA7);

        // R7: window length
        send(2, 0, 1, 8'h33);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R7 window length", n, WC);

        // R11: status byte and unused kind
        send(2, 0, 3, 8'h44);
        rd(2, 0, 0, v);
        chk("R11 status busy", v, 1);
        send(1, 0, 0, 8'h12);
        chk("R2 load during window", lane(0), 8'h12);
        idle_wait();
        rd(2, 0, 0, v);
        chk("R11 status idle", v, 0);
        rd(3, 1, 1, v);
        chk("R11 kind3 zero", v, 0);

        // R8: protect blocks all stores
        wp_n = 1'b0;
        send(2, 1, 1, 8'hEE);
        chk("R8 no window", int'(busy), 0);
        send(4, 1, 1, 0);
        send(6, 0, 2, 0);
        chk("R8 no window global", int'(busy), 0);
        rd(1, 1, 1, v);
        chk("R8 slot kept", v, val(1, 1));
        rd(1, 0, 2, v);
        chk("R8 global slot kept", v, val(0, 2));
        wp_n = 1'b1;

        // R9: stores during window dropped, window not extended
        send(2, 2, 0, 8'h11);
        n = 1;
        for (int i = 0; busy; i++) begin
            if (i == 2) begin
                cmd_op = 4'd2; cmd_pot = 2'd2; cmd_slot = 2'd0; cmd_data = 8'h99;
                cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            if (busy) n++;
        end
        cmd_valid = 1'b0;
        chk("R9 window not extended", n, WC);
        rd(1, 2, 0, v);
        chk("R9 store dropped", v, 8'h11);

        // R5: single copies
        send(3, 2, 0, 0);
        chk("R5 slot to wiper", lane(2), 8'h11);
        send(1, 3, 0, 8'h6B);
        send(4, 3, 1, 0);
        idle_wait();
        rd(1, 3, 1, v);
        chk("R5 wiper to slot", v, 8'h6B);

        // R6: global copies
        send(5, 1, 2, 0);
        chk("R6 global p0", lane(0), val(0, 2));
        chk("R6 global p1", lane(1), val(1, 2));
        chk("R6 global p2", lane(2), val(2, 2));
        chk("R6 global p3", lane(3), 8'hA7);
        for (int p = 0; p < 4; p++) send(1, p, 0, 8'h20 + p);
        send(6, 2, 3, 0);
        chk("R6 global store opens window", int'(busy), 1);
        idle_wait();
        for (int p = 0; p < 4; p++) begin
            rd(1, p, 3, v);
            chk("R6 global store slot3", v, 8'h20 + p);
        end

        // R10: stepping and saturation
        send(1, 0, 0, 8'hFE);
        send(7, 0, 0, 0);
        chk("R10 up to FF", lane(0), 8'hFF);
        send(7, 0, 0, 0);
        chk("R10 up saturates", lane(0), 8'hFF);
        send(1, 0, 0, 8'h01);
        send(8, 0, 0, 0);
        chk("R10 down to 00", lane(0), 0);
        send(8, 0, 0, 0);
        chk("R10 down saturates", lane(0), 0);

        // R12: undefined opcodes and idle strobes
        snap = int'(wiper_codes);
        send(0, 1, 0, 8'h77);
        send(9, 1, 0, 8'h77);
        send(15, 1, 0, 8'h77);
        cmd_op = 4'd1; cmd_pot = 2'd1; cmd_data = 8'h77; cmd_valid = 1'b0;
        @(negedge clk);
        chk("R12 wipers unchanged", int'(wiper_codes), snap);
        chk("R12 no window", int'(busy), 0);
        rd(1, 1, 0, v);
        chk("R12 slot unchanged", v, val(1, 0));

        // R4: retention through reset and recall of a new preset
        send(2, 1, 0, 8'h3C);
        idle_wait();
        pulse_reset();
        chk("R4 recall new preset", lane(1), 8'h3C);
        chk("R4 recall p3", lane(3), val(3, 0));
        rd(1, 3, 1, v);
        chk("R4 slot retained", v, 8'h6B);

        repeat (3) @(negedge clk);
        done = 1;
        report();
        $finish;
    end

endmodule